// File: doc/BRIEF.md
# Significance-Aware Register-and-ALU Slice

This block is one 4-bit slice of a cascadable datapath. It holds a 16-word scratchpad with two asynchronous read ports, a 16-function ALU, a shifter placed after the ALU, and a Q register that loads from the ALU result or shifts in place. Several slices are placed side by side. The carry, the scratchpad shift pins and the Q shift pins of each slice connect to its neighbours.

A 9-bit instruction controls the slice. Bits 8..5 pick the destination and the shift. Bits 4..1 pick the ALU function. Bit 0 picks the S operand. A 2-bit position code tells the slice whether it is the least significant, a middle or the most significant slice. The most significant slice keeps the sign during arithmetic shifts, and it puts its sign and overflow on the two pins that otherwise carry the active-low group generate and propagate. External data comes in on the S (B) operand side whenever the B port is not driving out. The same data can also be written straight into the scratchpad, bypassing the ALU.

Top module: `regslice_top`

## Requirements
- R1: A synchronous active-low reset clears the Q register and every scratchpad word to zero.
- R2: The instruction field instr[8:5] selects the destination and shift, instr[4:1] selects the ALU function, and instr[0] selects the S operand: 1 takes Q, 0 takes the B side.
- R3: The R operand is the scratchpad word at addr_a when a_en_n is 0, and zero when it is 1. When instr[0]=0, the S operand is the scratchpad word at addr_b if b_oe_n is 0, and ext_din if b_oe_n is 1.
- R4: The arithmetic function codes are 1 S+~R+cin, 2 R+~S+cin, 3 R+S+cin, 4 S+cin, 5 ~S+cin, 6 R+cin and 7 ~R+cin. The carry out of the top bit appears on cout.
- R5: The logic function codes are 0 all zeros, 8 all ones, 9 ~R&S, 10 XNOR, 11 XOR, 12 AND, 13 NOR, 14 NAND and 15 OR. cout is 0 for each of them.
- R6: Destination codes 0 and 1 shift the ALU result right, and codes 2 and 3 shift it left. The value goes to the word at addr_b and to y. A right shift fills bit 3 from ram_sin_hi and sends bit 0 out on ram_sout_lo. A left shift fills bit 0 from ram_sin_lo and sends bit 3 out on ram_sout_hi. Codes 1 and 3 are always logical, and codes 0 and 2 are logical when pos is not 2'b10. Code 4 writes the unshifted result.
- R7: When pos is 2'b10 (most significant), code 0 keeps bit 3 and copies it into bit 2. Code 2 keeps bit 3, moves bits 1..0 up into bits 2..1, fills bit 0 from ram_sin_lo and sends bit 2 out on ram_sout_hi. Position codes are 00 least significant, 01 middle and 10 most significant.
- R8: Code 5 loads Q from the ALU result. Code 6 loads both Q and the word at addr_b. Code 7 shifts Q right with fill from q_sin_hi. Code 8 shifts Q left with fill from q_sin_lo. q_sout_hi and q_sout_lo always show Q bit 3 and Q bit 0.
- R9: Code 9 writes ext_din directly into the word at addr_b, and y shows the ALU result.
- R10: b_dout drives the word at addr_b when b_oe_n is 0 and is high impedance when b_oe_n is 1.
- R11: On the most significant slice, g_or_sign shows result bit 3 and p_or_ovr shows the overflow (carry into bit 3 XOR carry out). On other slices they show the active-low group generate and propagate of the adder operands, using OR-propagate. Both are 1 for logic functions.
- R12: Codes 10 to 15 write neither the scratchpad nor Q, and y shows the ALU result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 9 | Destination, function and S-select fields |
| pos | input | 2 | Slice significance code |
| a_en_n | input | 1 | Active-low enable of the scratchpad A word onto R |
| b_oe_n | input | 1 | Active-low B-port output enable; high lets ext_din feed S |
| addr_a | input | 4 | Scratchpad A read address |
| addr_b | input | 4 | Scratchpad B read and write address |
| ext_din | input | 4 | External data in |
| cin | input | 1 | Carry in |
| ram_sin_lo | input | 1 | Left-shift fill from the lower neighbour |
| ram_sin_hi | input | 1 | Right-shift fill from the upper neighbour |
| q_sin_lo | input | 1 | Q left-shift fill |
| q_sin_hi | input | 1 | Q right-shift fill |
| y | output | 4 | Shifter output |
| b_dout | output | 4 | Tristate B-port data out |
| cout | output | 1 | Carry out |
| g_or_sign | output | 1 | Generate (active low) or sign on the top slice |
| p_or_ovr | output | 1 | Propagate (active low) or overflow on the top slice |
| ram_sout_lo | output | 1 | Bit shifted out at the low end |
| ram_sout_hi | output | 1 | Bit shifted out at the high end |
| q_sout_lo | output | 1 | Q bit 0 |
| q_sout_hi | output | 1 | Q bit 3 |

## Verification
The bench sets the slice to each of the three position codes and checks arithmetic shifts at each one. Arithmetic shifts must stay logical on lower slices. A slice that kept the sign on the wrong position, or used the fill pin instead of the copied sign, would give a wrong y and a wrong scratchpad word on the next read. The bench checks the generate and propagate pins in both their meanings: a slice that swapped or inverted them, or that left generate active during logic functions, would break carry-lookahead across slices. The bench also checks that b_oe_n switches S between the scratchpad and ext_din. A design that mixed these up would add the wrong operand while b_dout still looked correct.

// File: rtl/rs_pkg.sv
// Shared codes for the register-and-ALU slice: function, destination,
// position and shift-mode encodings. Assumes 4-bit instruction fields.
package rs_pkg;
    localparam logic [3:0] FN_ZERO = 4'd0;
    localparam logic [3:0] FN_SMR  = 4'd1;
    localparam logic [3:0] FN_RMS  = 4'd2;
    localparam logic [3:0] FN_ADD  = 4'd3;
    localparam logic [3:0] FN_SPC  = 4'd4;
    localparam logic [3:0] FN_NSPC = 4'd5;
    localparam logic [3:0] FN_RPC  = 4'd6;
    localparam logic [3:0] FN_NRPC = 4'd7;
    localparam logic [3:0] FN_ONES = 4'd8;
    localparam logic [3:0] FN_NRAS = 4'd9;
    localparam logic [3:0] FN_XNOR = 4'd10;
    localparam logic [3:0] FN_XOR  = 4'd11;
    localparam logic [3:0] FN_AND  = 4'd12;
    localparam logic [3:0] FN_NOR  = 4'd13;
    localparam logic [3:0] FN_NAND = 4'd14;
    localparam logic [3:0] FN_OR   = 4'd15;

    localparam logic [3:0] DS_RAM_ASR  = 4'd0;
    localparam logic [3:0] DS_RAM_LSR  = 4'd1;
    localparam logic [3:0] DS_RAM_ASL  = 4'd2;
    localparam logic [3:0] DS_RAM_LSL  = 4'd3;
    localparam logic [3:0] DS_RAM_LD   = 4'd4;
    localparam logic [3:0] DS_Q_LD     = 4'd5;
    localparam logic [3:0] DS_RAM_Q_LD = 4'd6;
    localparam logic [3:0] DS_Q_SR     = 4'd7;
    localparam logic [3:0] DS_Q_SL     = 4'd8;
    localparam logic [3:0] DS_EXT_WR   = 4'd9;

    localparam logic [1:0] POS_LSB = 2'b00;
    localparam logic [1:0] POS_MID = 2'b01;
    localparam logic [1:0] POS_MSB = 2'b10;

    localparam logic [1:0] SH_NONE  = 2'd0;
    localparam logic [1:0] SH_RIGHT = 2'd1;
    localparam logic [1:0] SH_LEFT  = 2'd2;

    // True for the seven adder-based function codes.
    function automatic logic fn_is_arith(input logic [3:0] fn);
        return (fn != FN_ZERO) && !fn[3];
    endfunction
endpackage

// File: rtl/rs_regfile.sv
// Scratchpad: DEPTH words, two asynchronous read ports, one synchronous
// write port. Assumes the write address equals the B read address upstream.
module rs_regfile #(
    parameter int DW = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [DW-1:0] da,
    output logic [DW-1:0] db
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Clear every word on reset, else write one word on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read ports.
    assign da = mem[ra];
    assign db = mem[rb];
endmodule

// File: rtl/rs_alu.sv
// ALU: 16 functions on R and S with carry in, carry out, overflow and
// OR-propagate group generate/propagate. Logic functions report no carry.
module rs_alu
    import rs_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic [3:0]    fn,
    input  logic [DW-1:0] r,
    input  logic [DW-1:0] s,
    input  logic          cin,
    output logic [DW-1:0] f,
    output logic          cout,
    output logic          ovr,
    output logic          grp_g,
    output logic          grp_p
);
    logic [DW-1:0] x, y;
    logic [DW:0]   sum;
    logic          arith;
    logic          c_top;

    // Pick the adder operands for each arithmetic code.
    always_comb begin
        arith = fn_is_arith(fn);
        case (fn)
            FN_SMR:  begin x = ~r;   y = s;   end
            FN_RMS:  begin x = r;    y = ~s;  end
            FN_ADD:  begin x = r;    y = s;   end
            FN_SPC:  begin x = '0;   y = s;   end
            FN_NSPC: begin x = '0;   y = ~s;  end
            FN_RPC:  begin x = r;    y = '0;  end
            FN_NRPC: begin x = ~r;   y = '0;  end
            default: begin x = '0;   y = '0;  end
        endcase
    end

    assign sum = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};

    // Result select between adder and the logic operations.
    always_comb begin
        case (fn)
            FN_ZERO: f = '0;
            FN_ONES: f = '1;
            FN_NRAS: f = ~r & s;
            FN_XNOR: f = ~(r ^ s);
            FN_XOR:  f = r ^ s;
            FN_AND:  f = r & s;
            FN_NOR:  f = ~(r | s);
            FN_NAND: f = ~(r & s);
            FN_OR:   f = r | s;
            default: f = sum[DW-1:0];
        endcase
    end

    // Carry into the top bit recovered from its sum bit.
    assign c_top = x[DW-1] ^ y[DW-1] ^ sum[DW-1];
    assign cout  = arith & sum[DW];
    assign ovr   = arith & (c_top ^ sum[DW]);

    // Ripple the group generate/propagate terms from bit 0 upward.
    always_comb begin
        logic gg, pp;
        gg = 1'b0;
        pp = 1'b1;
        for (int i = 0; i < DW; i++) begin
            gg = (x[i] & y[i]) | ((x[i] | y[i]) & gg);
            pp = pp & (x[i] | y[i]);
        end
        grp_g = arith & gg;
        grp_p = arith & pp;
    end
endmodule

// File: rtl/rs_shifter.sv
// One-place shifter with neighbour fill pins. On the most significant slice
// an arithmetic shift keeps the sign bit. Assumes DW >= 3.
module rs_shifter
    import rs_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic [1:0]    mode,
    input  logic          arith,
    input  logic          is_msb,
    input  logic [DW-1:0] din,
    input  logic          fill_lo,
    input  logic          fill_hi,
    output logic [DW-1:0] dout,
    output logic          out_lo,
    output logic          out_hi
);
    logic keep_sign;

    assign keep_sign = arith & is_msb;

    // Form the shifted word and the bit leaving the high end.
    always_comb begin
        out_hi = din[DW-1];
        case (mode)
            SH_RIGHT: dout = keep_sign ? {din[DW-1], din[DW-1:1]}
                                       : {fill_hi, din[DW-1:1]};
            SH_LEFT: begin
                if (keep_sign) begin
                    dout   = {din[DW-1], din[DW-3:0], fill_lo};
                    out_hi = din[DW-2];
                end else begin
                    dout   = {din[DW-2:0], fill_lo};
                end
            end
            default: dout = din;
        endcase
    end

    assign out_lo = din[0];
endmodule

// File: rtl/regslice_top.sv
// Register-and-ALU slice top: operand selection, scratchpad, ALU, result
// shifter, Q register and its shifter, and position-dependent flag pins.
// Assumes scratchpad writes target addr_b; all register updates on rising clk.
module regslice_top
    import rs_pkg::*;
#(
    parameter int DW = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [8:0]    instr,
    input  logic [1:0]    pos,
    input  logic          a_en_n,
    input  logic          b_oe_n,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] ext_din,
    input  logic          cin,
    input  logic          ram_sin_lo,
    input  logic          ram_sin_hi,
    input  logic          q_sin_lo,
    input  logic          q_sin_hi,
    output logic [DW-1:0] y,
    output wire  [DW-1:0] b_dout,
    output logic          cout,
    output logic          g_or_sign,
    output logic          p_or_ovr,
    output logic          ram_sout_lo,
    output logic          ram_sout_hi,
    output logic          q_sout_lo,
    output logic          q_sout_hi
);
    logic [3:0]    dest, fn;
    logic          s_from_q, is_msb;
    logic [DW-1:0] rd_a, rd_b, opr, ops;
    logic [DW-1:0] alu_f, ram_shf, q_reg, q_shf, ram_wdata;
    logic          alu_ovr, grp_g, grp_p, ram_we, q_out_hi, q_out_lo;
    logic [1:0]    ram_mode, q_mode;
    logic          ram_arith;

    assign dest     = instr[8:5];
    assign fn       = instr[4:1];
    assign s_from_q = instr[0];
    assign is_msb   = (pos == POS_MSB);

    // Operand selection: R from A port or zero, S from Q, B port or ext_din.
    assign opr = a_en_n ? '0 : rd_a;
    assign ops = s_from_q ? q_reg : (b_oe_n ? ext_din : rd_b);

    rs_regfile #(.DW(DW), .AW(AW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(addr_b),
        .wdata(ram_wdata), .ra(addr_a), .rb(addr_b), .da(rd_a), .db(rd_b)
    );

    rs_alu #(.DW(DW)) u_alu (
        .fn(fn), .r(opr), .s(ops), .cin(cin), .f(alu_f), .cout(cout),
        .ovr(alu_ovr), .grp_g(grp_g), .grp_p(grp_p)
    );

    // Decode the destination into shift modes and write enables.
    always_comb begin
        ram_mode  = SH_NONE;
        q_mode    = SH_NONE;
        ram_arith = (dest == DS_RAM_ASR) || (dest == DS_RAM_ASL);
        if (dest == DS_RAM_ASR || dest == DS_RAM_LSR) ram_mode = SH_RIGHT;
        if (dest == DS_RAM_ASL || dest == DS_RAM_LSL) ram_mode = SH_LEFT;
        if (dest == DS_Q_SR) q_mode = SH_RIGHT;
        if (dest == DS_Q_SL) q_mode = SH_LEFT;
        ram_we    = (dest <= DS_RAM_LD) || (dest == DS_RAM_Q_LD) ||
                    (dest == DS_EXT_WR);
        ram_wdata = (dest == DS_EXT_WR) ? ext_din : ram_shf;
    end

    rs_shifter #(.DW(DW)) u_ram_sh (
        .mode(ram_mode), .arith(ram_arith), .is_msb(is_msb), .din(alu_f),
        .fill_lo(ram_sin_lo), .fill_hi(ram_sin_hi), .dout(ram_shf),
        .out_lo(ram_sout_lo), .out_hi(ram_sout_hi)
    );

    rs_shifter #(.DW(DW)) u_q_sh (
        .mode(q_mode), .arith(1'b0), .is_msb(is_msb), .din(q_reg),
        .fill_lo(q_sin_lo), .fill_hi(q_sin_hi), .dout(q_shf),
        .out_lo(q_out_lo), .out_hi(q_out_hi)
    );

    // Q register: reset, load from ALU, or shift in place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_reg <= '0;
        end else if (dest == DS_Q_LD || dest == DS_RAM_Q_LD) begin
            q_reg <= alu_f;
        end else if (dest == DS_Q_SR || dest == DS_Q_SL) begin
            q_reg <= q_shf;
        end
    end

    assign q_sout_hi = q_out_hi;
    assign q_sout_lo = q_out_lo;
    assign y         = ram_shf;

    // Flag pins: sign and overflow on the top slice, else active-low G/P.
    always_comb begin
        if (is_msb) begin
            g_or_sign = alu_f[DW-1];
            p_or_ovr  = alu_ovr;
        end else begin
            g_or_sign = ~grp_g;
            p_or_ovr  = ~grp_p;
        end
    end

    // Tristate B-port output.
    assign b_dout = b_oe_n ? {DW{1'bz}} : rd_b;

    // R8
    q_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dest == DS_Q_LD) |=> (q_reg == $past(alu_f)));

    // R12
    q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dest > DS_EXT_WR) |=> $stable(q_reg));

    // R5
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_is_arith(fn) |-> !cout);

    // R7
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_msb && dest == DS_RAM_ASR) |-> (y[DW-1] == alu_f[DW-1]));

    // R11
    gp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_msb && !fn_is_arith(fn)) |-> (g_or_sign && p_or_ovr));
endmodule

// File: tb/sim_regslice_top.sv
// Bench for regslice_top: a behavioural integer model is stepped beside the
// design and every output is compared once per clock, away from the edge.
module sim_regslice_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] instr = '0;
    logic [1:0] pos = 2'b00;
    logic       a_en_n = 1'b1, b_oe_n = 1'b1;
    logic [3:0] addr_a = '0, addr_b = '0, ext_din = '0;
    logic       cin = 1'b0;
    logic       ram_sin_lo = 1'b0, ram_sin_hi = 1'b0, q_sin_lo = 1'b0, q_sin_hi = 1'b0;
    logic [3:0] y;
    wire  [3:0] b_dout;
    logic       cout, g_or_sign, p_or_ovr;
    logic       ram_sout_lo, ram_sout_hi, q_sout_lo, q_sout_hi;

    int checks = 0;
    int errors = 0;
    int mem [16];
    int qm;
    logic [31:0] lf = 32'h1ACE_5EED;

    regslice_top u0 (
        .clk(clk), .rst_n(rst_n), .instr(instr), .pos(pos), .a_en_n(a_en_n),
        .b_oe_n(b_oe_n), .addr_a(addr_a), .addr_b(addr_b), .ext_din(ext_din),
        .cin(cin), .ram_sin_lo(ram_sin_lo), .ram_sin_hi(ram_sin_hi),
        .q_sin_lo(q_sin_lo), .q_sin_hi(q_sin_hi), .y(y), .b_dout(b_dout),
        .cout(cout), .g_or_sign(g_or_sign), .p_or_ovr(p_or_ovr),
        .ram_sout_lo(ram_sout_lo), .ram_sout_hi(ram_sout_hi),
        .q_sout_lo(q_sout_lo), .q_sout_hi(q_sout_hi)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string name, input logic [3:0] act,
                       input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, name, act, exp);
        end
    endtask

    // Compare all outputs mid-cycle, then advance the model at the edge.
    task automatic step(input string force_tag);
        int dest, fn, r, s, x, yv, f, co, ov, gg, pp, sh, shi, slo, tot;
        bit arith, msb;
        string tg, ytag;
        logic [3:0] bexp;
        #5;
        dest = int'(instr[8:5]);
        fn = int'(instr[4:1]);
        msb = (pos == 2'b10);
        r = a_en_n ? 0 : mem[addr_a];
        s = instr[0] ? qm : (b_oe_n ? int'(ext_din) : mem[addr_b]);
        arith = (fn >= 1 && fn <= 7);
        x = 0; yv = 0; co = 0; ov = 0; gg = 0; pp = 0; f = 0;
        case (fn)
            1: begin x = 15 - r; yv = s; end
            2: begin x = r; yv = 15 - s; end
            3: begin x = r; yv = s; end
            4: begin x = 0; yv = s; end
            5: begin x = 0; yv = 15 - s; end
            6: begin x = r; yv = 0; end
            7: begin x = 15 - r; yv = 0; end
            0: f = 0;
            8: f = 15;
            9: f = (r ^ 15) & s;
            10: f = (r ^ s) ^ 15;
            11: f = r ^ s;
            12: f = r & s;
            13: f = (r | s) ^ 15;
            14: f = (r & s) ^ 15;
            default: f = r | s;
        endcase
        if (arith) begin
            tot = x + yv + int'(cin);
            f = tot % 16;
            co = tot / 16;
            ov = (((x ^ f) & (yv ^ f) & 8) != 0) ? 1 : 0;
            gg = (x + yv > 15) ? 1 : 0;
            pp = ((x | yv) == 15) ? 1 : 0;
        end
        sh = f; shi = (f >> 3) & 1; slo = f & 1;
        if (dest == 0 || dest == 1) begin
            if (dest == 0 && msb) sh = (f & 8) | (f >> 1);
            else sh = (int'(ram_sin_hi) << 3) | (f >> 1);
        end else if (dest == 2 || dest == 3) begin
            if (dest == 2 && msb) begin
                sh = (f & 8) | ((f & 3) << 1) | int'(ram_sin_lo);
                shi = (f >> 2) & 1;
            end else sh = ((f << 1) & 15) | int'(ram_sin_lo);
        end
        if (force_tag != "") ytag = force_tag;
        else if (dest <= 3) ytag = (msb && (dest == 0 || dest == 2)) ? "R7" : "R6";
        else if (dest >= 5 && dest <= 8) ytag = "R8";
        else if (dest == 9) ytag = "R9";
        else if (dest >= 10) ytag = "R12";
        else ytag = arith ? "R4" : "R5";
        chk(ytag, "y", y, 4'(sh));
        tg = arith ? "R4" : "R5";
        chk(tg, "cout", {3'b0, cout}, 4'(co));
        if (msb) begin
            chk("R11", "sign", {3'b0, g_or_sign}, 4'((f >> 3) & 1));
            chk("R11", "ovr", {3'b0, p_or_ovr}, 4'(ov));
        end else begin
            chk("R11", "gen_n", {3'b0, g_or_sign}, 4'(1 - gg));
            chk("R11", "prop_n", {3'b0, p_or_ovr}, 4'(1 - pp));
        end
        tg = (msb && dest == 2) ? "R7" : "R6";
        chk(tg, "sout_hi", {3'b0, ram_sout_hi}, 4'(shi));
        chk("R6", "sout_lo", {3'b0, ram_sout_lo}, 4'(slo));
        chk("R8", "q_sout_hi", {3'b0, q_sout_hi}, 4'((qm >> 3) & 1));
        chk("R8", "q_sout_lo", {3'b0, q_sout_lo}, 4'(qm & 1));
        bexp = b_oe_n ? 4'bzzzz : 4'(mem[addr_b]);
        chk("R10", "b_dout", b_dout, bexp);
        @(posedge clk);
        if (rst_n) begin
            if (dest <= 4 || dest == 6) mem[addr_b] = sh;
            if (dest == 9) mem[addr_b] = int'(ext_din);
            if (dest == 5 || dest == 6) qm = f;
            if (dest == 7) qm = (int'(q_sin_hi) << 3) | (qm >> 1);
            if (dest == 8) qm = ((qm << 1) & 15) | int'(q_sin_lo);
        end
        @(negedge clk);
    endtask

    task automatic set_op(input int dest, input int fn, input bit qs);
        instr = {4'(dest), 4'(fn), qs};
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 0;
        qm = 0;
        // Dirty state before reset so reset clearing is visible (R1).
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            addr_b = 4'(i); ext_din = 4'(15 - (i % 7)); set_op(9, 3, 0);
            @(negedge clk);
        end
        set_op(5, 8, 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every word and Q read back as zero.
        b_oe_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            addr_b = 4'(i); set_op(12, 3, 0);
            step("R1");
        end
        b_oe_n = 1'b1;
        set_op(12, 4, 1); cin = 1'b0;
        step("R1");
        // R9 then R3: write two words directly, then select operands.
        addr_b = 4'd3; ext_din = 4'd5; set_op(9, 0, 0); step("R9");
        addr_b = 4'd7; ext_din = 4'd9; set_op(9, 8, 0); step("R9");
        addr_a = 4'd3; a_en_n = 1'b0; b_oe_n = 1'b0; set_op(12, 3, 0); step("R3");
        a_en_n = 1'b1; step("R3");
        b_oe_n = 1'b1; ext_din = 4'd2; a_en_n = 1'b0; step("R3");
        // R2: the same word fields with S taken from Q.
        set_op(5, 3, 0); step("R2");
        set_op(12, 3, 1); step("R2");
        set_op(4, 11, 1); step("R2");
        // Mixed stream across all three positions.
        for (int n = 0; n < 1800; n++) begin
            lf = nxt(lf); lf = nxt(lf);
            instr = lf[8:0];
            pos = (n < 600) ? 2'b00 : ((n < 1200) ? 2'b01 : 2'b10);
            a_en_n = lf[9]; b_oe_n = lf[10]; addr_a = lf[14:11];
            addr_b = lf[18:15]; ext_din = lf[22:19]; cin = lf[23];
            ram_sin_lo = lf[24]; ram_sin_hi = lf[25];
            q_sin_lo = lf[26]; q_sin_hi = lf[27];
            step("");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule